// File: doc/BRIEF.md
# Width-Selectable Subtract Unit with Borrow Forms

This block is the subtract datapath of a 16-bit integer execution stage. It takes a first operand X and a second operand Y and produces either X−Y or Y−X. Each of these two directions also has a borrow form, which subtracts one more whenever the incoming carry flag is clear. The carry flag therefore acts as an inverted borrow. Y comes from a register value, a zero-extended 5-bit literal or a sign-extended 10-bit literal. The unit runs at full word width or on the low byte only.

The unit registers each request it accepts. One cycle later it presents the result and a fresh set of condition flags: negative, overflow, zero, a sticky zero, digit carry and carry. Every flag is evaluated at the selected width. The sticky zero can only be cleared, never set, so a chain of partial subtractions can test a multi-word value for zero. Fetching operands and writing back results are handled outside this block.

Top module: `sub_alu`

## Requirements
- R1: `op_form` selects the operation. Code 0 gives X−Y, code 1 gives Y−X, code 2 gives X−Y−(1−C) and code 3 gives Y−X−(1−C), where C is `carry_flag_in`. The result wraps modulo 2^16 in word mode.
- R2: In codes 2 and 3, `carry_flag_in`=1 subtracts nothing extra and `carry_flag_in`=0 subtracts one more. Codes 0 and 1 ignore `carry_flag_in`.
- R3: `byte_mode`=1 makes the operation 8 bits wide. `result[7:0]` then holds the byte result and `result[15:8]` equals `x_in[15:8]` for every form. `byte_mode`=0 selects the 16-bit word.
- R4: `y_src` picks Y. Code 0 or 3 takes `y_reg`. Code 1 takes `lit_in[4:0]` zero-extended, giving 0 to 31. Code 2 takes all of `lit_in` sign-extended, giving −512 to 511.
- R5: Flag vector layout is bit 0 C, bit 1 Z, bit 2 OV, bit 3 N, bit 4 DC, bit 5 SZ. C is 1 exactly when the minuend, taken unsigned at the selected width, is at least the subtrahend plus the borrow, so C=1 means no borrow.
- R6: DC is the carry out of bit 3 in byte mode and out of bit 7 in word mode. It is 1 when the low nibble (byte mode) or low byte (word mode) of the minuend is at least the same field of the subtrahend plus the borrow.
- R7: OV is 1 when the signed difference at the selected width lies outside that width's two's-complement range.
- R8: N equals the result's top bit at the selected width. Z is 1 exactly when the result bits at that width are all zero.
- R9: SZ is 0 after a nonzero result and equals `sticky_zero_in` after a zero result.
- R10: `out_valid` is high in the cycle after a cycle with `op_valid` high and low otherwise. `result` and `flags_out` do not change after a cycle with `op_valid` low.
- R11: A synchronous active-high `rst` clears `out_valid`, `result` and `flags_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe; the other inputs are taken in this cycle |
| op_form | input | 2 | Operation code (R1) |
| y_src | input | 2 | Second-operand source (R4) |
| byte_mode | input | 1 | 1 = byte width, 0 = word width |
| x_in | input | 16 | First operand X |
| y_reg | input | 16 | Register value for Y |
| lit_in | input | 10 | Literal field for Y |
| carry_flag_in | input | 1 | Current C flag (inverted borrow) |
| sticky_zero_in | input | 1 | Current SZ flag |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 16 | Difference |
| flags_out | output | 6 | {SZ, DC, N, OV, Z, C} |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, an 8-bit byte lane, a 5-bit unsigned literal and a 10-bit signed literal. At these sizes the byte lane's sign boundary at 0x80 and the word's at 0x8000 are reachable, as are both digit-carry positions (bits 3 and 7) and the literal extremes of 31, −512 and 511. The bench drives each of the four forms with the carry flag both set and clear. It also covers zero results with the incoming sticky zero both high and low, and it checks that the upper byte passes through unchanged in byte mode.

// File: rtl/sub_alu_pkg.sv
package sub_alu_pkg;

    typedef enum logic [1:0] {
        FORM_FWD      = 2'd0,
        FORM_REV      = 2'd1,
        FORM_FWD_BRW  = 2'd2,
        FORM_REV_BRW  = 2'd3
    } sub_form_e;

    typedef enum logic [1:0] {
        YSRC_REG   = 2'd0,
        YSRC_ULIT  = 2'd1,
        YSRC_SLIT  = 2'd2,
        YSRC_REG2  = 2'd3
    } y_src_e;

    localparam int FLAG_W = 6;

    typedef struct packed {
        logic sz;
        logic dc;
        logic n;
        logic ov;
        logic z;
        logic c;
    } sub_flags_t;

    function automatic logic form_is_reverse(sub_form_e f);
        return f[0];
    endfunction

    function automatic logic form_uses_borrow(sub_form_e f);
        return f[1];
    endfunction

endpackage

// File: rtl/sub_opnd_mux.sv
module sub_opnd_mux
    import sub_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ULIT_W = 5,
    parameter int SLIT_W = 10
) (
    input  y_src_e              src,
    input  logic [DATA_W-1:0]   y_reg,
    input  logic [SLIT_W-1:0]   lit,
    output logic [DATA_W-1:0]   y_val
);
    localparam int UPAD = DATA_W - ULIT_W;
    localparam int SPAD = DATA_W - SLIT_W;

    always_comb begin
        unique case (src)
            YSRC_ULIT: y_val = {{UPAD{1'b0}}, lit[ULIT_W-1:0]};
            YSRC_SLIT: y_val = {{SPAD{lit[SLIT_W-1]}}, lit};
            default:   y_val = y_reg;
        endcase
    end
endmodule

// File: rtl/sub_core.sv
module sub_core
    import sub_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sub_form_e           form,
    input  logic                byte_mode,
    input  logic [DATA_W-1:0]   x,
    input  logic [DATA_W-1:0]   y,
    input  logic                c_in,
    input  logic                sz_in,
    output logic [DATA_W-1:0]   res,
    output sub_flags_t          flags
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int MSB_W   = DATA_W - 1;
    localparam int MSB_B   = HALF_W - 1;
    localparam int DC_W    = HALF_W - 1;
    localparam int DC_B    = HALF_W / 2 - 1;

    logic [DATA_W-1:0] a, b, nb;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] cout;

    always_comb begin
        a   = form_is_reverse(form) ? y : x;
        b   = form_is_reverse(form) ? x : y;
        nb  = ~b;
        cin = form_uses_borrow(form) ? c_in : 1'b1;
        sum = {1'b0, a} + {1'b0, nb} + {{DATA_W{1'b0}}, cin};
    end

    // Per-bit carry recovered from the single adder
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W - 1; gi++) begin : g_carry
            assign cout[gi] = sum[gi+1] ^ a[gi+1] ^ nb[gi+1];
        end
    endgenerate
    assign cout[DATA_W-1] = sum[DATA_W];

    logic msb_r, msb_a, msb_b, zero;

    always_comb begin
        msb_r = byte_mode ? sum[MSB_B] : sum[MSB_W];
        msb_a = byte_mode ? a[MSB_B]   : a[MSB_W];
        msb_b = byte_mode ? b[MSB_B]   : b[MSB_W];
        zero  = byte_mode ? (sum[HALF_W-1:0] == '0) : (sum[DATA_W-1:0] == '0);

        flags.c  = byte_mode ? cout[MSB_B] : cout[MSB_W];
        flags.dc = byte_mode ? cout[DC_B]  : cout[DC_W];
        flags.n  = msb_r;
        flags.ov = (msb_a ^ msb_b) & (msb_r ^ msb_a);
        flags.z  = zero;
        flags.sz = zero & sz_in;

        res = byte_mode ? {x[DATA_W-1:HALF_W], sum[HALF_W-1:0]} : sum[DATA_W-1:0];
    end
endmodule

// File: rtl/sub_alu.sv
module sub_alu
    import sub_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ULIT_W = 5,
    parameter int SLIT_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [1:0]          op_form,
    input  logic [1:0]          y_src,
    input  logic                byte_mode,
    input  logic [DATA_W-1:0]   x_in,
    input  logic [DATA_W-1:0]   y_reg,
    input  logic [SLIT_W-1:0]   lit_in,
    input  logic                carry_flag_in,
    input  logic                sticky_zero_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [FLAG_W-1:0]   flags_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] y_val, res_d;
    sub_flags_t        flags_d;

    sub_opnd_mux #(.DATA_W(DATA_W), .ULIT_W(ULIT_W), .SLIT_W(SLIT_W)) u_mux (
        .src   (y_src_e'(y_src)),
        .y_reg (y_reg),
        .lit   (lit_in),
        .y_val (y_val)
    );

    sub_core #(.DATA_W(DATA_W)) u_core (
        .form      (sub_form_e'(op_form)),
        .byte_mode (byte_mode),
        .x         (x_in),
        .y         (y_val),
        .c_in      (carry_flag_in),
        .sz_in     (sticky_zero_in),
        .res       (res_d),
        .flags     (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= op_valid;
            if (op_valid) begin
                result    <= res_d;
                flags_out <= flags_d;
            end
        end
    end

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> out_valid);
    p_valid_drops_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !out_valid);
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(result) && $stable(flags_out)));
    p_upper_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && byte_mode) |=> (result[DATA_W-1:HALF_W] == $past(x_in[DATA_W-1:HALF_W])));
    p_sz_no_set_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sticky_zero_in) |=> !flags_out[5]);
    p_word_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !byte_mode) |=> (flags_out[1] == (result == '0)));
endmodule

// File: tb/sub_alu_tb_top.sv
module sub_alu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_form, y_src;
    logic        byte_mode;
    logic [15:0] x_in, y_reg;
    logic [9:0]  lit_in;
    logic        carry_flag_in, sticky_zero_in;
    logic        out_valid;
    logic [15:0] result;
    logic [5:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sub_alu dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_form(op_form),
        .y_src(y_src), .byte_mode(byte_mode), .x_in(x_in), .y_reg(y_reg),
        .lit_in(lit_in), .carry_flag_in(carry_flag_in),
        .sticky_zero_in(sticky_zero_in), .out_valid(out_valid),
        .result(result), .flags_out(flags_out)
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Independent integer model: {flags, result}
    function automatic logic [21:0] model(logic [1:0] form, logic [1:0] src, logic bm,
                                          logic [15:0] x, logic [15:0] yr, logic [9:0] lit,
                                          logic cf, logic szf);
        int yv, a, b, brw, w, mask, au, bu, diff, hm, sa, sb, sd, r;
        logic c, dc, ov, n, z, sz;
        logic [15:0] res;
        case (src)
            2'd1:    yv = int'(lit[4:0]);
            2'd2:    yv = int'($signed(lit)) & 32'hFFFF;
            default: yv = int'(yr);
        endcase
        a   = form[0] ? yv : int'(x);
        b   = form[0] ? int'(x) : yv;
        brw = (form[1] && !cf) ? 1 : 0;
        w    = bm ? 8 : 16;
        mask = (1 << w) - 1;
        au = a & mask;
        bu = b & mask;
        diff = au - bu - brw;
        c = (diff >= 0);
        r = diff & mask;
        hm = bm ? 15 : 255;
        dc = (((a & hm) - (b & hm) - brw) >= 0);
        sa = (au >= (1 << (w-1))) ? au - (1 << w) : au;
        sb = (bu >= (1 << (w-1))) ? bu - (1 << w) : bu;
        sd = sa - sb - brw;
        ov = (sd > (1 << (w-1)) - 1) || (sd < -(1 << (w-1)));
        n  = ((r >> (w-1)) & 1) == 1;
        z  = (r == 0);
        sz = z ? szf : 1'b0;
        res = bm ? {x[15:8], 8'(r)} : 16'(r);
        return {sz, dc, n, ov, z, c, res};
    endfunction

    task automatic run_op(string tag, logic [1:0] form, logic [1:0] src, logic bm,
                          logic [15:0] x, logic [15:0] yr, logic [9:0] lit,
                          logic cf, logic szf);
        logic [21:0] exp;
        exp = model(form, src, bm, x, yr, lit, cf, szf);
        @(negedge clk);
        op_valid = 1'b1; op_form = form; y_src = src; byte_mode = bm;
        x_in = x; y_reg = yr; lit_in = lit; carry_flag_in = cf; sticky_zero_in = szf;
        @(negedge clk);
        op_valid = 1'b0;
        check(tag, "out_valid", {15'd0, out_valid}, 16'd1);
        check(tag, "result", result, exp[15:0]);
        check(tag, "flags", {10'd0, flags_out}, {10'd0, exp[21:16]});
    endtask

    task automatic t_reset;
        check("R11", "out_valid", {15'd0, out_valid}, 16'd0);
        check("R11", "result", result, 16'h0000);
        check("R11", "flags", {10'd0, flags_out}, 16'd0);
    endtask

    task automatic t_forms;
        for (int f = 0; f < 4; f++) begin
            run_op("R1", 2'(f), 2'd0, 1'b0, 16'h1234, 16'h0234, 10'd0, 1'b1, 1'b0);
            run_op("R2", 2'(f), 2'd0, 1'b0, 16'h1234, 16'h0234, 10'd0, 1'b0, 1'b0);
        end
        // Literal expectation: 0x1234 - 0x0234 - 1 = 0x0FFF
        run_op("R2", 2'd2, 2'd0, 1'b0, 16'h1234, 16'h0234, 10'd0, 1'b0, 1'b0);
        check("R2", "borrow literal", result, 16'h0FFF);
        run_op("R5", 2'd0, 2'd0, 1'b0, 16'h0001, 16'h0002, 10'd0, 1'b1, 1'b0);
        check("R5", "C on borrow", {15'd0, flags_out[0]}, 16'd0);
        run_op("R5", 2'd1, 2'd0, 1'b0, 16'h0001, 16'h0002, 10'd0, 1'b1, 1'b0);
        check("R5", "C no borrow", {15'd0, flags_out[0]}, 16'd1);
    endtask

    task automatic t_byte;
        run_op("R3", 2'd0, 2'd0, 1'b1, 16'hAB10, 16'h0020, 10'd0, 1'b1, 1'b0);
        check("R3", "byte result", result, 16'hABF0);
        run_op("R3", 2'd3, 2'd0, 1'b1, 16'h5A05, 16'h77F0, 10'd0, 1'b0, 1'b0);
        check("R3", "upper from x", {8'd0, result[15:8]}, 16'h005A);
    endtask

    task automatic t_literals;
        run_op("R4", 2'd0, 2'd1, 1'b0, 16'h0100, 16'h1111, 10'h3FF, 1'b1, 1'b0);
        check("R4", "ulit 31", result, 16'h00E1);
        run_op("R4", 2'd1, 2'd2, 1'b0, 16'h0001, 16'h1111, 10'h200, 1'b1, 1'b0);
        check("R4", "slit -512", result, 16'hFDFF);
        run_op("R4", 2'd0, 2'd2, 1'b0, 16'h0000, 16'h1111, 10'h1FF, 1'b1, 1'b0);
        check("R4", "slit 511", result, 16'hFE01);
        run_op("R4", 2'd0, 2'd3, 1'b0, 16'h0050, 16'h0010, 10'h3FF, 1'b1, 1'b0);
        check("R4", "reg alt", result, 16'h0040);
        run_op("R4", 2'd0, 2'd2, 1'b1, 16'h3300, 16'h0000, 10'h3FF, 1'b1, 1'b0);
        check("R4", "slit byte", result, 16'h3301);
    endtask

    task automatic t_digit;
        run_op("R6", 2'd0, 2'd0, 1'b0, 16'h0100, 16'h0001, 10'd0, 1'b1, 1'b0);
        check("R6", "word dc borrow", {15'd0, flags_out[4]}, 16'd0);
        run_op("R6", 2'd0, 2'd0, 1'b0, 16'h01FF, 16'h0001, 10'd0, 1'b1, 1'b0);
        check("R6", "word dc clean", {15'd0, flags_out[4]}, 16'd1);
        run_op("R6", 2'd0, 2'd0, 1'b1, 16'h0010, 16'h0001, 10'd0, 1'b1, 1'b0);
        check("R6", "byte dc borrow", {15'd0, flags_out[4]}, 16'd0);
        run_op("R6", 2'd2, 2'd0, 1'b1, 16'h000F, 16'h000E, 10'd0, 1'b0, 1'b0);
        check("R6", "byte dc edge", {15'd0, flags_out[4]}, 16'd1);
    endtask

    task automatic t_overflow;
        run_op("R7", 2'd0, 2'd0, 1'b0, 16'h8000, 16'h0001, 10'd0, 1'b1, 1'b0);
        check("R7", "word ov", {15'd0, flags_out[2]}, 16'd1);
        run_op("R7", 2'd0, 2'd0, 1'b1, 16'h1280, 16'h0001, 10'd0, 1'b1, 1'b0);
        check("R7", "byte ov", {15'd0, flags_out[2]}, 16'd1);
        run_op("R7", 2'd2, 2'd0, 1'b0, 16'h8000, 16'h0000, 10'd0, 1'b0, 1'b0);
        check("R7", "borrow ov", {15'd0, flags_out[2]}, 16'd1);
        run_op("R8", 2'd0, 2'd0, 1'b0, 16'h0001, 16'h0002, 10'd0, 1'b1, 1'b0);
        check("R8", "N word", {15'd0, flags_out[3]}, 16'd1);
        check("R7", "no ov", {15'd0, flags_out[2]}, 16'd0);
    endtask

    task automatic t_zero;
        run_op("R9", 2'd0, 2'd0, 1'b0, 16'h4444, 16'h4444, 10'd0, 1'b1, 1'b1);
        check("R9", "sz kept", {14'd0, flags_out[5], flags_out[1]}, 16'd3);
        run_op("R9", 2'd0, 2'd0, 1'b0, 16'h4444, 16'h4444, 10'd0, 1'b1, 1'b0);
        check("R9", "sz stays low", {15'd0, flags_out[5]}, 16'd0);
        run_op("R9", 2'd0, 2'd0, 1'b0, 16'h4445, 16'h4444, 10'd0, 1'b1, 1'b1);
        check("R9", "sz cleared", {15'd0, flags_out[5]}, 16'd0);
        run_op("R8", 2'd0, 2'd0, 1'b1, 16'h7733, 16'h0033, 10'd0, 1'b1, 1'b1);
        check("R8", "byte Z", {15'd0, flags_out[1]}, 16'd1);
    endtask

    task automatic t_hold;
        logic [15:0] r0;
        logic [5:0]  f0;
        run_op("R10", 2'd1, 2'd0, 1'b0, 16'h0003, 16'h0009, 10'd0, 1'b1, 1'b0);
        r0 = result; f0 = flags_out;
        @(negedge clk);
        x_in = 16'hFFFF; y_reg = 16'h0000; op_form = 2'd0; carry_flag_in = 1'b0;
        @(negedge clk);
        check("R10", "idle valid", {15'd0, out_valid}, 16'd0);
        check("R10", "idle result", result, r0);
        check("R10", "idle flags", {10'd0, flags_out}, {10'd0, f0});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_form = 2'd0; y_src = 2'd0; byte_mode = 1'b0;
        x_in = '0; y_reg = '0; lit_in = '0; carry_flag_in = 1'b0; sticky_zero_in = 1'b0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_forms;
        t_byte;
        t_literals;
        t_digit;
        t_overflow;
        t_zero;
        t_hold;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule